// File: doc/BRIEF.md
# Prioritized Up/Down Counter

A small wrap-around counter whose next value is picked by three control lines with a fixed order of precedence. A low level on the clear line empties the counter at the next rising clock edge, whatever the other two lines say. When the clear line is high, the count line decides whether the counter moves at all. A high level on the count line freezes the value. A low level lets the counter step once per clock, in the direction given by the direction line.

Inside, the block is split into four parts. A step unit forms the value plus one and the value minus one. A decoder turns the three control lines into a two-bit select code. A per-bit four-way multiplexer chooses among zero, the present value, the step-up value and the step-down value. A plain register holds the result. The width is a parameter and defaults to two bits, giving the sequence 0..3. The register output is the state itself.

Top module: `prio_updn_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` is 0 after that edge, whatever `run_n` and `dir_dn` are.
- R2: When `clr_n` is high and `run_n` is high at a rising edge, `count` keeps its value across that edge and `dir_dn` has no effect.
- R3: When `clr_n` is high, `run_n` is low and `dir_dn` is low at a rising edge, `count` becomes its previous value plus one.
- R4: When `clr_n` is high, `run_n` is low and `dir_dn` is high at a rising edge, `count` becomes its previous value minus one.
- R5: Counting up from the all-ones value (3 at the default width) gives 0.
- R6: Counting down from 0 gives the all-ones value (3 at the default width).
- R7: Control lines act only at the rising clock edge. Changes between edges leave `count` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest precedence |
| run_n | input | 1 | Count enable, active low; high freezes the value |
| dir_dn | input | 1 | Direction: low counts up, high counts down |
| count | output | WIDTH | Present state of the counter |

## Verification
The clear and a counting step can be requested in the same cycle. The bench does this by holding `run_n` low with each value of `dir_dn` while `clr_n` is low, with the counter away from zero, and expects zero rather than a neighbour value. The freeze and the direction line can also arrive together. Here `dir_dn` is toggled while `run_n` is high, and the bench expects an unchanged count. Glitches between edges are judged by sampling `count` both before and after the following edge.

// File: rtl/prio_updn_pkg.sv
package prio_updn_pkg;

   // Select code for the next-state multiplexer; bit 1 picks the pair,
   // bit 0 picks within the pair.
   typedef enum logic [1:0] {
      NS_ZERO = 2'b00,
      NS_HOLD = 2'b01,
      NS_UP   = 2'b10,
      NS_DOWN = 2'b11
   } ns_sel_e;

   // Step unit implementation variants.
   localparam int STEP_ARITH  = 0;
   localparam int STEP_RIPPLE = 1;

endpackage

// File: rtl/updn_step.sv
module updn_step #(
   parameter int WIDTH     = 2,
   parameter int STEP_IMPL = prio_updn_pkg::STEP_RIPPLE
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] inc,
   output logic [WIDTH-1:0] dec
);

   if (WIDTH < 1) begin : g_width_chk
      $error("updn_step: WIDTH must be at least 1");
   end
   if (STEP_IMPL != prio_updn_pkg::STEP_ARITH &&
       STEP_IMPL != prio_updn_pkg::STEP_RIPPLE) begin : g_impl_chk
      $error("updn_step: unknown STEP_IMPL");
   end

   if (STEP_IMPL == prio_updn_pkg::STEP_ARITH) begin : g_arith
      localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
      assign inc = cur + ONE;
      assign dec = cur - ONE;
   end else begin : g_ripple
      logic [WIDTH-1:0] carry;
      logic [WIDTH-1:0] borrow;
      assign carry[0]  = 1'b1;
      assign borrow[0] = 1'b1;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign inc[i] = cur[i] ^ carry[i];
         assign dec[i] = cur[i] ^ borrow[i];
         if (i < WIDTH - 1) begin : g_chain
            assign carry[i+1]  = cur[i]  & carry[i];
            assign borrow[i+1] = ~cur[i] & borrow[i];
         end
      end
   end

endmodule

// File: rtl/prio_decode.sv
module prio_decode
   import prio_updn_pkg::*;
(
   input  logic    clr_n,
   input  logic    run_n,
   input  logic    dir_dn,
   output ns_sel_e sel
);

   always_comb begin
      if (!clr_n)      sel = NS_ZERO;
      else if (run_n)  sel = NS_HOLD;
      else if (dir_dn) sel = NS_DOWN;
      else             sel = NS_UP;
   end

endmodule

// File: rtl/mux4_bus.sv
module mux4_bus
   import prio_updn_pkg::*;
#(
   parameter int WIDTH = 2
) (
   input  ns_sel_e          sel,
   input  logic [WIDTH-1:0] d_zero,
   input  logic [WIDTH-1:0] d_hold,
   input  logic [WIDTH-1:0] d_up,
   input  logic [WIDTH-1:0] d_down,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_width_chk
      $error("mux4_bus: WIDTH must be at least 1");
   end

   logic [1:0] s;
   assign s = sel;

   // One bit slice per output bit: two 2:1 stages, then a final 2:1.
   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      logic lo_pair;
      logic hi_pair;
      assign lo_pair = s[0] ? d_hold[i] : d_zero[i];
      assign hi_pair = s[0] ? d_down[i] : d_up[i];
      assign q[i]    = s[1] ? hi_pair   : lo_pair;
   end

endmodule

// File: rtl/state_reg.sv
module state_reg #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/prio_updn_counter.sv
module prio_updn_counter
   import prio_updn_pkg::*;
#(
   parameter int WIDTH     = 2,
   parameter int STEP_IMPL = STEP_RIPPLE
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             run_n,
   input  logic             dir_dn,
   output logic [WIDTH-1:0] count
);

   if (WIDTH < 1) begin : g_width_chk
      $error("prio_updn_counter: WIDTH must be at least 1");
   end

   localparam logic [WIDTH-1:0] ZERO_VAL = '0;

   ns_sel_e          sel;
   logic [WIDTH-1:0] up_val;
   logic [WIDTH-1:0] down_val;
   logic [WIDTH-1:0] next_val;

   updn_step #(
      .WIDTH    (WIDTH),
      .STEP_IMPL(STEP_IMPL)
   ) u_step (
      .cur(count),
      .inc(up_val),
      .dec(down_val)
   );

   prio_decode u_dec (
      .clr_n (clr_n),
      .run_n (run_n),
      .dir_dn(dir_dn),
      .sel   (sel)
   );

   mux4_bus #(
      .WIDTH(WIDTH)
   ) u_mux (
      .sel   (sel),
      .d_zero(ZERO_VAL),
      .d_hold(count),
      .d_up  (up_val),
      .d_down(down_val),
      .q     (next_val)
   );

   state_reg #(
      .WIDTH(WIDTH)
   ) u_reg (
      .clk(clk),
      .d  (next_val),
      .q  (count)
   );

endmodule

// File: rtl/prio_updn_counter_chk.sv
module prio_updn_counter_chk #(
   parameter int WIDTH = 2
) (
   input logic             clk,
   input logic             clr_n,
   input logic             run_n,
   input logic             dir_dn,
   input logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] ONE_STEP = WIDTH'(1);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   // The state is defined only once a clear has been taken.
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   p_clear_wins_r1: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> (count == '0));

   p_freeze_r2: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && run_n) |=> $stable(count));

   p_step_up_r3: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && !dir_dn) |=> ((count - $past(count)) == ONE_STEP));

   p_step_down_r4: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && dir_dn) |=> (($past(count) - count) == ONE_STEP));

   p_wrap_top_r5: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && !dir_dn && count == ALL_ONES) |=> (count == '0));

   p_wrap_bottom_r6: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !run_n && dir_dn && count == '0) |=> (count == ALL_ONES));

endmodule

bind prio_updn_counter prio_updn_counter_chk #(
   .WIDTH(WIDTH)
) u_chk (
   .clk   (clk),
   .clr_n (clr_n),
   .run_n (run_n),
   .dir_dn(dir_dn),
   .count (count)
);

// File: tb/prio_updn_counter_bench.sv
module prio_updn_counter_bench;

   localparam int W = 2;
   localparam logic [W-1:0] TOP = '1;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         run_n = 1'b1;
   logic         dir_dn = 1'b0;
   logic [W-1:0] count;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   logic [W-1:0] model = '0;

   always #5 clk = ~clk;

   prio_updn_counter #(.WIDTH(W)) u_prio_updn_counter (
      .clk   (clk),
      .clr_n (clr_n),
      .run_n (run_n),
      .dir_dn(dir_dn),
      .count (count)
   );

   task automatic check(input string req, input logic [W-1:0] exp);
      n_checks++;
      if (count !== exp) begin
         n_fail++;
         $display("FAIL %s: count=%0d expected=%0d at %0t", req, count, exp, $time);
      end
   endtask

   // Drive at the falling edge, let one rising edge pass, sample 2 ns later.
   task automatic apply(input logic c, input logic r, input logic d, input string req);
      @(negedge clk);
      clr_n = c; run_n = r; dir_dn = d;
      @(posedge clk);
      #2;
      if (!c)      model = '0;
      else if (r)  model = model;
      else if (d)  model = model - 1'b1;
      else         model = model + 1'b1;
      check(req, model);
   endtask

   task automatic t_reset();
      apply(1'b0, 1'b1, 1'b0, "R1 clear");
      apply(1'b0, 1'b0, 1'b0, "R1 clear with up request");
   endtask

   task automatic t_up_run();
      for (int i = 0; i < 6; i++) begin
         if (model == TOP) apply(1'b1, 1'b0, 1'b0, "R5 wrap up");
         else              apply(1'b1, 1'b0, 1'b0, "R3 step up");
      end
   endtask

   task automatic t_down_run();
      apply(1'b0, 1'b1, 1'b1, "R1 clear before down run");
      for (int i = 0; i < 6; i++) begin
         if (model == '0) apply(1'b1, 1'b0, 1'b1, "R6 wrap down");
         else             apply(1'b1, 1'b0, 1'b1, "R4 step down");
      end
   endtask

   task automatic t_hold();
      apply(1'b1, 1'b0, 1'b0, "R3 step up to set value");
      apply(1'b1, 1'b1, 1'b0, "R2 hold dir low");
      apply(1'b1, 1'b1, 1'b1, "R2 hold dir high");
      apply(1'b1, 1'b1, 1'b0, "R2 hold dir toggled");
   endtask

   task automatic t_clear_vs_count();
      apply(1'b1, 1'b0, 1'b0, "R3 step up");
      apply(1'b1, 1'b0, 1'b0, "R3 step up");
      apply(1'b0, 1'b0, 1'b0, "R1 clear beats up");
      apply(1'b1, 1'b0, 1'b1, "R6 wrap down from cleared");
      apply(1'b0, 1'b0, 1'b1, "R1 clear beats down");
      apply(1'b1, 1'b0, 1'b1, "R6 wrap down");
      apply(1'b0, 1'b1, 1'b0, "R1 clear beats hold");
   endtask

   task automatic t_between_edges();
      apply(1'b1, 1'b0, 1'b0, "R3 step up");
      @(negedge clk);
      clr_n = 1'b0; run_n = 1'b0;
      #1; dir_dn = 1'b1;
      #1; clr_n = 1'b1;
      #1; check("R7 no change between edges", model);
      clr_n = 1'b1; run_n = 1'b1; dir_dn = 1'b0;
      @(posedge clk);
      #2;
      check("R7 glitch ignored at edge", model);
   endtask

   initial begin
      @(posedge clk);
      #2;
      t_reset();
      t_up_run();
      t_down_run();
      t_hold();
      t_clear_vs_count();
      t_between_edges();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #20000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule